// File: doc/BRIEF.md
# Cascaded H-Bridge Cell Selector

Once per control interval, this block decides how the nine cells of one phase leg of a cascaded H-bridge converter produce the voltage asked of that leg. A control interval is one 1 ms period of a 1 kHz update rate.

The block takes these inputs:
- a signed leg voltage demand;
- the measured capacitor voltage of every cell, as unsigned codes;
- a power-flow flag, which is 1 when power leaves the leg;
- a half-cycle flag, which is 1 in the negative half of the fundamental.

The block ranks the cells by capacitor voltage. The ranking runs from highest to lowest when power flows out of the leg, and from lowest to highest when power flows in. Cells are taken from the head of the ranking while their running sum stays within the magnitude of the demand. These cells conduct for the whole interval, with the polarity set by the half-cycle flag. The next cell in the ranking makes up the leftover voltage by centre-aligned PWM. Every other cell outputs zero. This charges the weakest capacitors and discharges the strongest ones.

A start strobe launches one computation. The new cell codes and duty appear together with a one-cycle valid pulse. At that moment the triangular PWM carrier restarts, so the on-pulse sits in the middle of the new interval. One carrier period is 2^(DW+1) clocks, which gives the 1 ms interval with a 2.048 MHz clock at DW = 10.

Top module: `chb_cell_selector`

## Requirements
- R1: The ranking is descending in voltage when `flow_out_i` = 1 and ascending when it is 0. Equal voltages are always ranked lower cell index first.
- R2: Cells are taken from the head of the ranking as full cells while the running sum of their voltages is at or below |demand|. The first cell that would exceed |demand| ends the walk.
- R3: The cell that ends the walk gets code 2'b11 (PWM). `duty_o` = floor((|demand| − S) · 2^DW / v), where S is the sum of the full cells and v is the voltage of the PWM cell. A zero demand therefore gives the head cell code 11 with duty 0.
- R4: Full cells get code 2'b01 when `half_neg_i` = 0 and code 2'b10 when it is 1. The sign of `demand_i` has no effect; only its magnitude is used.
- R5: Cell k's code sits at `cell_state_o[2k+1:2k]`. Cells that are neither full nor PWM get 2'b00.
- R6: When |demand| is at or above the sum of all cell voltages, every cell is full, no cell has code 11 and `duty_o` = 0.
- R7: `valid_o` is a one-cycle pulse DW+2 rising edges after the edge that samples `start_i`. Codes and duty change only at that pulse. A `start_i` seen while a computation is in progress is ignored.
- R8: From the cycle of `valid_o`, call that cycle t = 0. `pwm_o` is high exactly for cycles t in [2^DW − duty, 2^DW − 1 + duty] of each 2^(DW+1)-cycle carrier period. The pulse width is therefore 2·duty cycles, centred on the carrier peak.
- R9: After reset all codes are 00, and `duty_o`, `pwm_o` and `valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch one selection for the next interval |
| demand_i | input | SUM_W+1 (21) | Signed leg voltage demand, in cell-voltage LSBs |
| cell_v_i | input | N_CELLS·VW (144) | Cell k capacitor voltage at bits [16k+15:16k] |
| flow_out_i | input | 1 | 1: power leaves the leg; 0: power enters |
| half_neg_i | input | 1 | 1: negative half of the fundamental |
| cell_state_o | output | 2·N_CELLS (18) | Per-cell code: 00 zero, 01 positive, 10 negative, 11 PWM |
| duty_o | output | DW (10) | Residual duty as a fraction of 2^DW |
| pwm_o | output | 1 | Centre-aligned gate for the PWM cell |
| valid_o | output | 1 | One-cycle pulse when new codes take effect |

## Verification
The assertions check these properties on every cycle:
- the sorter output is strictly ordered under the active direction and tie rule;
- at most one cell carries the PWM code;
- the duty is zero whenever no PWM cell exists;
- the divider remainder stays below its divisor;
- the latched demand holds while a computation runs;
- the carrier trough never gates the PWM cell on.

Some behaviour only the bench scenarios can show, by comparing against an independent model:
- the exact choice of full and PWM cells;
- the duty arithmetic;
- the equal-voltage ordering;
- the over-range case;
- the latency;
- the position and width of the PWM pulse.

// File: rtl/chb_sel_pkg.sv
package chb_sel_pkg;
  typedef enum logic [1:0] {
    CELL_ZERO = 2'b00,
    CELL_POS  = 2'b01,
    CELL_NEG  = 2'b10,
    CELL_PWM  = 2'b11
  } cell_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PICK,
    ST_DIV
  } sel_state_e;
endpackage

// File: rtl/chb_rank_sorter.sv
// Odd-even transposition network; a strict total order (voltage, then index) makes it stable.
module chb_rank_sorter #(
  parameter int N  = 9,
  parameter int VW = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          desc_i,
  input  logic [VW-1:0] v_i   [N],
  output logic [VW-1:0] v_o   [N],
  output logic [IW-1:0] idx_o [N]
);
  function automatic logic ahead(input logic desc,
                                 input logic [VW-1:0] va, input logic [IW-1:0] ia,
                                 input logic [VW-1:0] vb, input logic [IW-1:0] ib);
    if (va == vb) return ia < ib;
    return desc ? (va > vb) : (va < vb);
  endfunction

  logic [VW-1:0] vs [N+1][N];
  logic [IW-1:0] xs [N+1][N];

  for (genvar k = 0; k < N; k++) begin : g_in
    assign vs[0][k] = v_i[k];
    assign xs[0][k] = IW'(k);
  end

  for (genvar s = 0; s < N; s++) begin : g_stage
    localparam int OFS = s % 2;
    for (genvar k = 0; k < N; k++) begin : g_el
      if (k >= OFS && (k - OFS) % 2 == 0 && k + 1 < N) begin : g_lo
        logic sw;
        assign sw = ahead(desc_i, vs[s][k+1], xs[s][k+1], vs[s][k], xs[s][k]);
        assign vs[s+1][k] = sw ? vs[s][k+1] : vs[s][k];
        assign xs[s+1][k] = sw ? xs[s][k+1] : xs[s][k];
      end else if (k - 1 >= OFS && (k - 1 - OFS) % 2 == 0) begin : g_hi
        logic sw;
        assign sw = ahead(desc_i, vs[s][k], xs[s][k], vs[s][k-1], xs[s][k-1]);
        assign vs[s+1][k] = sw ? vs[s][k-1] : vs[s][k];
        assign xs[s+1][k] = sw ? xs[s][k-1] : xs[s][k];
      end else begin : g_pass
        assign vs[s+1][k] = vs[s][k];
        assign xs[s+1][k] = xs[s][k];
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_out
    assign v_o[k]   = vs[N][k];
    assign idx_o[k] = xs[N][k];
  end
endmodule

// File: rtl/chb_frac_divider.sv
// Restoring fraction divider: quot = floor(num * 2^DW / den), requires num < den.
module chb_frac_divider #(
  parameter int VW = 16,
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [VW-1:0] num_i,
  input  logic [VW-1:0] den_i,
  output logic [DW-1:0] quot_o,
  output logic          done_o
);
  localparam int CW = $clog2(DW + 1);

  logic [VW:0]   rem_q;
  logic [VW-1:0] den_q;
  logic [DW-1:0] quot_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [VW:0]   sh;

  assign sh = {rem_q[VW-1:0], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quot_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= {1'b0, num_i};
      den_q  <= den_i;
      quot_q <= '0;
      cnt_q  <= CW'(DW);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        if (sh >= {1'b0, den_q}) begin
          rem_q  <= sh - {1'b0, den_q};
          quot_q <= {quot_q[DW-2:0], 1'b1};
        end else begin
          rem_q  <= sh;
          quot_q <= {quot_q[DW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign quot_o = quot_q;
  assign done_o = busy_q && (cnt_q == '0);

  // R3: partial remainder never reaches the divisor, so the quotient is a proper fraction
  a_r3_rem_below_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (rem_q < {1'b0, den_q}));
endmodule

// File: rtl/chb_center_pwm.sv
// Up/down carrier 0..2^DW-1..0; gate high while carrier + duty exceeds the peak.
module chb_center_pwm #(
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [DW-1:0] duty_i,
  output logic          pwm_o
);
  localparam logic [DW-1:0] PEAK = '1;

  logic [DW-1:0] cnt_q;
  logic          up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (restart_i) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (cnt_q == PEAK) up_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end else begin
      if (cnt_q == '0) up_q <= 1'b1;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pwm_o = ({1'b0, cnt_q} + {1'b0, duty_i}) > {1'b0, PEAK};

  // R8: the carrier trough always lies outside the centred pulse
  a_r8_trough_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> !pwm_o);
  // R8: the carrier steps by one while rising below the peak
  a_r8_carrier_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && cnt_q != PEAK && !restart_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/chb_cell_selector.sv
module chb_cell_selector
  import chb_sel_pkg::*;
#(
  parameter int N_CELLS = 9,
  parameter int VW      = 16,
  parameter int DW      = 10,
  parameter int SUM_W   = VW + $clog2(N_CELLS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic signed [SUM_W:0]   demand_i,
  input  logic [N_CELLS*VW-1:0]   cell_v_i,
  input  logic                    flow_out_i,
  input  logic                    half_neg_i,
  output logic [2*N_CELLS-1:0]    cell_state_o,
  output logic [DW-1:0]           duty_o,
  output logic                    pwm_o,
  output logic                    valid_o
);
  localparam int IW = $clog2(N_CELLS);

  sel_state_e           st_q;
  logic [VW-1:0]        cv_q [N_CELLS];
  logic [SUM_W:0]       mag_q, dmd_abs;
  logic                 flow_q, half_q;
  logic [VW-1:0]        rk_v [N_CELLS];
  logic [IW-1:0]        rk_i [N_CELLS];
  logic [2*N_CELLS-1:0] pend_d, pend_q;
  logic [VW-1:0]        num_d, den_d;
  logic [DW-1:0]        quot;
  logic                 div_done;
  logic [N_CELLS-1:0]   pwm_mask;

  assign dmd_abs = demand_i[SUM_W] ? $unsigned(-demand_i) : $unsigned(demand_i);

  chb_rank_sorter #(.N(N_CELLS), .VW(VW), .IW(IW)) u_sort (
    .desc_i (flow_q),
    .v_i    (cv_q),
    .v_o    (rk_v),
    .idx_o  (rk_i)
  );

  // Walk the ranking: full cells while the running sum fits, then one PWM cell
  always_comb begin
    logic [SUM_W:0] acc, nxt;
    logic           hit;
    acc    = '0;
    hit    = 1'b0;
    pend_d = '0;
    num_d  = '0;
    den_d  = VW'(1);
    for (int k = 0; k < N_CELLS; k++) begin
      nxt = acc + (SUM_W+1)'(rk_v[k]);
      if (!hit) begin
        if (nxt <= mag_q) begin
          acc = nxt;
          pend_d[{rk_i[k], 1'b0} +: 2] = half_q ? CELL_NEG : CELL_POS;
        end else begin
          hit   = 1'b1;
          num_d = VW'(mag_q - acc);
          den_d = rk_v[k];
          pend_d[{rk_i[k], 1'b0} +: 2] = CELL_PWM;
        end
      end
    end
  end

  chb_frac_divider #(.VW(VW), .DW(DW)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (st_q == ST_PICK),
    .num_i   (num_d),
    .den_i   (den_d),
    .quot_o  (quot),
    .done_o  (div_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      for (int k = 0; k < N_CELLS; k++) cv_q[k] <= '0;
      mag_q        <= '0;
      flow_q       <= 1'b0;
      half_q       <= 1'b0;
      pend_q       <= '0;
      cell_state_o <= '0;
      duty_o       <= '0;
      valid_o      <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          for (int k = 0; k < N_CELLS; k++) cv_q[k] <= cell_v_i[k*VW +: VW];
          mag_q  <= dmd_abs;
          flow_q <= flow_out_i;
          half_q <= half_neg_i;
          st_q   <= ST_PICK;
        end
        ST_PICK: begin
          pend_q <= pend_d;
          st_q   <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          cell_state_o <= pend_q;
          duty_o       <= quot;
          valid_o      <= 1'b1;
          st_q         <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  chb_center_pwm #(.DW(DW)) u_pwm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (st_q == ST_DIV && div_done),
    .duty_i    (duty_o),
    .pwm_o     (pwm_o)
  );

  always_comb begin
    for (int k = 0; k < N_CELLS; k++) pwm_mask[k] = &cell_state_o[2*k +: 2];
  end

  // R1: sorter output respects direction and lower-index-first tie rule
  for (genvar k = 0; k + 1 < N_CELLS; k++) begin : g_ord
    a_r1_rank_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_PICK) |->
        ((rk_v[k] == rk_v[k+1]) ? (rk_i[k] < rk_i[k+1])
                                : (flow_q ? (rk_v[k] > rk_v[k+1]) : (rk_v[k] < rk_v[k+1]))));
  end
  // R3: never more than one modulated cell
  a_r3_single_pwm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pwm_mask) <= 1);
  // R6: no modulated cell implies zero duty
  a_r6_zero_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_mask == '0) |-> (duty_o == '0));
  // R7: latched request holds while busy
  a_r7_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> $stable(mag_q) && $stable(half_q) && $stable(flow_q));
  // R7: result strobe lasts one cycle
  a_r7_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: tb/chb_cell_selector_test.sv
module chb_cell_selector_test;
  localparam int N = 9, VW = 16, DW = 10, SUM_W = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                  rst_n, start, flow_out, half_neg;
  logic signed [SUM_W:0] demand;
  logic [N*VW-1:0]       cell_v;
  logic [2*N-1:0]        cell_state;
  logic [DW-1:0]         duty;
  logic                  pwm, valid;

  chb_cell_selector #(.N_CELLS(N), .VW(VW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .demand_i(demand),
    .cell_v_i(cell_v), .flow_out_i(flow_out), .half_neg_i(half_neg),
    .cell_state_o(cell_state), .duty_o(duty), .pwm_o(pwm), .valid_o(valid)
  );

  int n_chk = 0, n_bad = 0;
  logic [2*N-1:0] exp_st_q[$];
  logic [DW-1:0]  exp_du_q[$];
  string          exp_tag_q[$];
  int unsigned    vt[N];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference: rank, walk, residual fraction
  function automatic void model(input int unsigned v[N], input int mag, input bit fo,
                                input bit hn, output logic [2*N-1:0] st,
                                output logic [DW-1:0] du);
    int ord[N];
    bit used[N];
    int acc;
    bit hit;
    for (int c = 0; c < N; c++) used[c] = 0;
    for (int p = 0; p < N; p++) begin
      int best;
      best = -1;
      for (int c = 0; c < N; c++) begin
        if (!used[c]) begin
          if (best < 0) best = c;
          else if (v[c] != v[best] && (fo ? (v[c] > v[best]) : (v[c] < v[best]))) best = c;
        end
      end
      ord[p] = best;
      used[best] = 1;
    end
    st = '0; du = '0; acc = 0; hit = 0;
    for (int p = 0; p < N; p++) begin
      int c;
      c = ord[p];
      if (!hit) begin
        if (acc + int'(v[c]) <= mag) begin
          acc += int'(v[c]);
          st[2*c +: 2] = hn ? 2'b10 : 2'b01;
        end else begin
          hit = 1;
          st[2*c +: 2] = 2'b11;
          du = DW'(((mag - acc) * 1024) / int'(v[c]));
        end
      end
    end
  endfunction

  // Driver: push expectation, strobe start, check latency (R7)
  task automatic apply(input int dmd, input bit fo, input bit hn, input string tag,
                       input bit intrude);
    logic [2*N-1:0] es;
    logic [DW-1:0]  ed;
    model(vt, (dmd < 0) ? -dmd : dmd, fo, hn, es, ed);
    exp_st_q.push_back(es);
    exp_du_q.push_back(ed);
    exp_tag_q.push_back(tag);
    @(negedge clk);
    for (int k = 0; k < N; k++) cell_v[k*VW +: VW] = vt[k][VW-1:0];
    demand = SUM_W'(dmd);
    demand = dmd;
    flow_out = fo;
    half_neg = hn;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      repeat (2) @(negedge clk);
      demand = 21'sd5;
      half_neg = ~hn;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (8) @(negedge clk);
    end else begin
      repeat (11) @(negedge clk);
    end
    chk(valid == 1'b0, "R7", "valid early", valid, 0);
    @(negedge clk);
    chk(valid == 1'b1, "R7", "valid at DW+2", valid, 1);
  endtask

  // Called in the valid cycle (t=0): measure one carrier period (R8)
  task automatic check_pwm(input int d);
    int cnt, first;
    cnt = 0; first = -1;
    for (int t = 0; t < 2048; t++) begin
      if (pwm) begin
        cnt++;
        if (first < 0) first = t;
      end
      @(negedge clk);
    end
    chk(cnt == 2 * d, "R8", "pwm high cycles", cnt, 2 * d);
    chk(first == ((d > 0) ? 1024 - d : -1), "R8", "pwm first high", first,
        (d > 0) ? 1024 - d : -1);
  endtask

  // Monitor: scoreboard compare on each result strobe
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_st_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected result", cell_state, 0);
      end else begin
        logic [2*N-1:0] es;
        logic [DW-1:0]  ed;
        string          tg;
        es = exp_st_q.pop_front();
        ed = exp_du_q.pop_front();
        tg = exp_tag_q.pop_front();
        chk(cell_state == es, tg, "cell codes", cell_state, es);
        chk(duty == ed, tg, "duty", duty, ed);
      end
    end
  end

  bit finished = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; demand = '0; cell_v = '0; flow_out = 1'b0; half_neg = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(cell_state == '0, "R9", "reset codes", cell_state, 0);
    chk(duty == '0, "R9", "reset duty", duty, 0);
    chk(pwm == 1'b0 && valid == 1'b0, "R9", "reset pwm/valid", {pwm, valid}, 0);

    vt = '{30000, 12000, 45000, 8000, 25000, 45000, 500, 18000, 33000};
    // R1 descending with R2/R3 residual, R5 zeros, R8 pulse
    apply(100000, 1, 0, "R1_R2_R3_R5 desc", 0);
    check_pwm(310);
    // R1 ascending
    apply(100000, 0, 0, "R1_R2 asc", 0);
    // R4: negative demand, negative half: magnitude only, codes 10
    apply(-100000, 1, 1, "R4 sign/half", 0);
    // R6: exactly total and above total
    apply(216500, 1, 0, "R6 equal total", 0);
    apply(300000, 0, 1, "R6 over total", 0);
    check_pwm(0);
    // R3: zero demand -> head cell modulated, duty 0
    apply(0, 1, 0, "R3 zero demand", 0);
    // R2/R3 ascending small demand: 500 full, 6500/8000 -> 832
    apply(7000, 0, 0, "R2_R3 small asc", 0);
    check_pwm(832);
    // R1 ties: equal cells -> lower index first; 0,1 full, 2 at 512
    vt = '{20000, 20000, 20000, 20000, 20000, 20000, 20000, 20000, 20000};
    apply(50000, 1, 0, "R1 tie desc", 0);
    chk(cell_state == 18'h00035, "R1", "tie codes literal", cell_state, 18'h00035);
    check_pwm(512);
    apply(50000, 0, 1, "R1 tie asc", 0);
    // R7: start during busy ignored
    vt = '{1000, 2000, 3000, 4000, 5000, 6000, 7000, 8000, 9000};
    apply(20000, 1, 0, "R7 busy ignore", 1);
    repeat (30) @(negedge clk);
    chk(exp_st_q.size() == 0, "R7", "pending results", exp_st_q.size(), 0);
    chk(cell_state[17:16] == 2'b01, "R7", "intruder not applied", cell_state[17:16], 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule